// File: doc/BRIEF.md
# Receiver and Oscillator Enable Sequencer

This block produces the two power-gating enables of a paging front end: one for the radio receiver and one for its RF oscillator. A synchronization state machine, kept outside this block, announces each upcoming sampling window. It does this by giving the number of clock ticks left before the window opens, and it raises a level while the window is open. Each enable has its own 4-bit lead time. An enable switches on once the remaining tick count has fallen to its lead value or below, and it stays on until the window closes. The two outputs are therefore sequenced independently, and the oscillator can settle over a different interval than the receiver.

A host can latch an override that holds both enables on continuously. The override leaves the data-sampling strobe untouched. It is released only by a host clear command or by reset. When the host turns monitoring on, a status bit mirrors the receiver enable. Each toggle of the receiver enable then latches an interrupt, which stays high until the host acknowledges it.

Top module: `rxosc_enable_ctrl`

## Requirements
- R1: While rst_n is 0, rx_en, osc_en, sample_en, stat_rx and irq are all 0, and the override is cleared.
- R2: rx_en is 1 in the cycle after any cycle in which win_open is 1, or win_eta_vld is 1 with win_eta <= rx_lead. Otherwise it is 0, unless the override is active.
- R3: osc_en follows the same rule as R2 using osc_lead, independently of rx_lead.
- R4: A lead of 0 keeps an enable off through the whole countdown (win_eta >= 1). The enable rises only in the cycle after win_open rises. A lead of 15 raises it in the cycle after win_eta reaches 15.
- R5: A one-cycle force_set pulse latches the override at the next edge. From the edge after that, rx_en and osc_en both stay 1, until the edge that follows a force_clr pulse. When force_set and force_clr are both 1 in the same cycle, the override is set.
- R6: sample_en equals win_open delayed by one cycle, whatever the override state.
- R7: stat_rx equals rx_en while mon_en is 1, and is 0 while mon_en is 0.
- R8: When rx_en differs from its value in the previous cycle and mon_en is 1 in that cycle, irq is 1 from the next edge. When mon_en is 0, an rx_en change does not set irq.
- R9: irq stays 1 until a cycle with irq_clr = 1, after which it is 0. If a new R8 event happens in the same cycle as irq_clr, irq stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one tick of the lead count |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_open | input | 1 | Sampling window currently open |
| win_eta_vld | input | 1 | win_eta holds a valid countdown |
| win_eta | input | ETA_W | Ticks left before the next window opens |
| rx_lead | input | LEAD_W | Receiver lead time in ticks |
| osc_lead | input | LEAD_W | Oscillator lead time in ticks |
| force_set | input | 1 | Host command: hold both enables on |
| force_clr | input | 1 | Host command: release the hold |
| mon_en | input | 1 | Host monitoring enable for the receiver enable |
| irq_clr | input | 1 | Host acknowledge of irq |
| rx_en | output | 1 | Receiver enable |
| osc_en | output | 1 | RF oscillator enable |
| sample_en | output | 1 | Data sampling strobe (window delayed one cycle) |
| stat_rx | output | 1 | Monitored copy of rx_en |
| irq | output | 1 | Sticky interrupt on rx_en change |

## Verification
The hardest case to reach from the ports is an irq acknowledge that lands in the same cycle as a fresh rx_en toggle. That needs a countdown timed so that the receiver enable rises exactly where the bench pulses irq_clr. The bench runs a countdown with a known rx_lead, so the rise cycle is known ahead of time, and pulses irq_clr in that cycle. A second boundary is a simultaneous override set and clear; the bench drives that as a single-cycle pulse pair and then runs a full window to show both enables stay held.

// File: rtl/enable_pkg.sv
package enable_pkg;
    parameter int LEAD_W = 4;
    parameter int ETA_W  = 6;
    parameter int N_EN   = 2;

    localparam int EN_RX  = 0;
    localparam int EN_OSC = 1;
endpackage

// File: rtl/enable_lead_gate.sv
module enable_lead_gate #(
    parameter int ETA_W  = 6,
    parameter int LEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_open,
    input  logic              eta_vld,
    input  logic [ETA_W-1:0]  eta,
    input  logic [LEAD_W-1:0] lead,
    input  logic              hold,
    output logic              en
);
    typedef struct packed {
        logic en;
    } gate_t;

    gate_t st_d, st_q;
    logic  in_lead;

    always_comb begin
        in_lead = eta_vld && (eta <= ETA_W'(lead));
        st_d    = st_q;
        st_d.en = hold || win_open || in_lead;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;

    // an open window always powers the stage on the next cycle
    p_open_powers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |=> en);
    // nothing requesting the stage: it drops
    p_idle_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !win_open && !eta_vld) |=> !en);
endmodule

// File: rtl/enable_force_latch.sv
module enable_force_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic on
);
    typedef struct packed {
        logic on;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.on = 1'b1;
        else if (clr_i) st_d.on = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on = st_q.on;

    p_hold_until_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !clr_i) |=> on);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> on);
endmodule

// File: rtl/enable_edge_irq.sv
module enable_edge_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic mon_en,
    input  logic clr_i,
    output logic irq
);
    typedef struct packed {
        logic prev;
        logic irq;
    } irq_t;

    irq_t st_d, st_q;
    logic toggled;

    always_comb begin
        toggled = mon_en && (level != st_q.prev);
        st_d      = st_q;
        st_d.prev = level;
        if (toggled)    st_d.irq = 1'b1;
        else if (clr_i) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_i) |=> irq);
    p_no_edge_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !mon_en) |=> !irq);
endmodule

// File: rtl/rxosc_enable_ctrl.sv
module rxosc_enable_ctrl
    import enable_pkg::*;
#(
    parameter int P_ETA_W  = ETA_W,
    parameter int P_LEAD_W = LEAD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_open,
    input  logic                win_eta_vld,
    input  logic [P_ETA_W-1:0]  win_eta,
    input  logic [P_LEAD_W-1:0] rx_lead,
    input  logic [P_LEAD_W-1:0] osc_lead,
    input  logic                force_set,
    input  logic                force_clr,
    input  logic                mon_en,
    input  logic                irq_clr,
    output logic                rx_en,
    output logic                osc_en,
    output logic                sample_en,
    output logic                stat_rx,
    output logic                irq
);
    typedef struct packed {
        logic sample;
    } top_t;

    top_t                top_d, top_q;
    logic                force_on;
    logic [N_EN-1:0]     en_vec;
    logic [P_LEAD_W-1:0] lead_vec [N_EN];

    assign lead_vec[EN_RX]  = rx_lead;
    assign lead_vec[EN_OSC] = osc_lead;

    enable_force_latch u_force (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (force_set),
        .clr_i (force_clr),
        .on    (force_on)
    );

    for (genvar g = 0; g < N_EN; g++) begin : g_gate
        enable_lead_gate #(
            .ETA_W  (P_ETA_W),
            .LEAD_W (P_LEAD_W)
        ) u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .win_open (win_open),
            .eta_vld  (win_eta_vld),
            .eta      (win_eta),
            .lead     (lead_vec[g]),
            .hold     (force_on),
            .en       (en_vec[g])
        );
    end

    enable_edge_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (en_vec[EN_RX]),
        .mon_en (mon_en),
        .clr_i  (irq_clr),
        .irq    (irq)
    );

    always_comb begin
        top_d        = top_q;
        top_d.sample = win_open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign rx_en     = en_vec[EN_RX];
    assign osc_en    = en_vec[EN_OSC];
    assign sample_en = top_q.sample;
    assign stat_rx   = mon_en & rx_en;

    p_force_both_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_on |=> (rx_en && osc_en));
    p_sample_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |=> sample_en);
    p_sample_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> !sample_en);
    p_mirror_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |-> !stat_rx);
endmodule

// File: tb/rxosc_enable_ctrl_tb.sv
`timescale 1ns/1ps
module rxosc_enable_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_open = 1'b0, win_eta_vld = 1'b0;
    logic [5:0] win_eta = '0;
    logic [3:0] rx_lead = '0, osc_lead = '0;
    logic       force_set = 1'b0, force_clr = 1'b0, mon_en = 1'b0, irq_clr = 1'b0;
    logic       rx_en, osc_en, sample_en, stat_rx, irq;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // bench model state
    bit m_force, m_rx, m_osc, m_samp, m_prev, m_irq;

    always #2.5 clk = ~clk;

    rxosc_enable_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .win_open(win_open), .win_eta_vld(win_eta_vld),
        .win_eta(win_eta), .rx_lead(rx_lead), .osc_lead(osc_lead),
        .force_set(force_set), .force_clr(force_clr), .mon_en(mon_en),
        .irq_clr(irq_clr), .rx_en(rx_en), .osc_en(osc_en),
        .sample_en(sample_en), .stat_rx(stat_rx), .irq(irq)
    );

    task automatic cmp(string tag, string what, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, "rx_en", rx_en, m_rx);
        cmp(tag, "osc_en", osc_en, m_osc);
        cmp(tag, "sample_en", sample_en, m_samp);
        cmp(tag, "stat_rx", stat_rx, mon_en & m_rx);
        cmp(tag, "irq", irq, m_irq);
    endtask

    // one clock: model advances from the inputs held over the edge
    task automatic step(string tag);
        bit rx_n, osc_n, irq_n;
        @(posedge clk);
        rx_n  = m_force || win_open || (win_eta_vld && (win_eta <= {2'b00, rx_lead}));
        osc_n = m_force || win_open || (win_eta_vld && (win_eta <= {2'b00, osc_lead}));
        if (mon_en && (m_rx != m_prev)) irq_n = 1'b1;
        else if (irq_clr)               irq_n = 1'b0;
        else                            irq_n = m_irq;
        m_prev = m_rx;
        m_rx   = rx_n;
        m_osc  = osc_n;
        m_samp = win_open;
        m_irq  = irq_n;
        if (force_set)      m_force = 1'b1;
        else if (force_clr) m_force = 1'b0;
        #1;
        check_all(tag);
    endtask

    task automatic run_window(string tag, int eta_from, int open_len, int idle_len);
        for (int e = eta_from; e >= 1; e--) begin
            win_eta_vld = 1'b1; win_eta = 6'(e); win_open = 1'b0;
            step(tag);
        end
        win_eta_vld = 1'b0; win_eta = '0;
        for (int k = 0; k < open_len; k++) begin
            win_open = 1'b1;
            step(tag);
        end
        win_open = 1'b0;
        for (int k = 0; k < idle_len; k++) step(tag);
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0;
        force_set = 1'b1; win_open = 1'b1; mon_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        m_force = 0; m_rx = 0; m_osc = 0; m_samp = 0; m_prev = 0; m_irq = 0;
        cmp("R1", "rx_en", rx_en, 1'b0);
        cmp("R1", "osc_en", osc_en, 1'b0);
        cmp("R1", "sample_en", sample_en, 1'b0);
        cmp("R1", "stat_rx", stat_rx, 1'b0);
        cmp("R1", "irq", irq, 1'b0);
        force_set = 1'b0; win_open = 1'b0; mon_en = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step("R1");
    endtask

    task automatic t_leads_r2_r3();
        rx_lead = 4'd5; osc_lead = 4'd2;
        run_window("R2 R3", 12, 4, 3);
        rx_lead = 4'd1; osc_lead = 4'd9;
        run_window("R2 R3", 10, 2, 3);
    endtask

    task automatic t_edge_leads_r4();
        rx_lead = 4'd0; osc_lead = 4'd15;
        run_window("R4", 20, 3, 2);
        rx_lead = 4'd15; osc_lead = 4'd0;
        run_window("R4", 16, 1, 2);
    endtask

    task automatic t_override_r5_r6();
        rx_lead = 4'd3; osc_lead = 4'd3;
        force_set = 1'b1; step("R5"); force_set = 1'b0;
        step("R5");
        run_window("R5 R6", 6, 3, 4);
        force_set = 1'b1; force_clr = 1'b1; step("R5");
        force_set = 1'b0; force_clr = 1'b0;
        run_window("R5 R6", 5, 2, 3);
        force_clr = 1'b1; step("R5"); force_clr = 1'b0;
        step("R5"); step("R5");
        run_window("R6", 5, 2, 3);
    endtask

    task automatic t_monitor_r7_r8();
        mon_en = 1'b0; rx_lead = 4'd4; osc_lead = 4'd1;
        run_window("R7 R8", 8, 3, 3);
        mon_en = 1'b1;
        run_window("R7 R8", 8, 3, 3);
        irq_clr = 1'b1; step("R8"); irq_clr = 1'b0;
        step("R8");
    endtask

    task automatic t_ack_r9();
        mon_en = 1'b1; rx_lead = 4'd2;
        for (int e = 6; e >= 3; e--) begin
            win_eta_vld = 1'b1; win_eta = 6'(e); step("R9");
        end
        // eta 2 reached: rx_en rises after this edge
        win_eta = 6'd2; step("R9");
        // ack exactly while the toggle is being seen: irq must stay
        win_eta = 6'd1; irq_clr = 1'b1; step("R9"); irq_clr = 1'b0;
        win_eta_vld = 1'b0;
        win_open = 1'b1; step("R9"); step("R9");
        win_open = 1'b0; step("R9");
        step("R9"); step("R9");
        irq_clr = 1'b1; step("R9"); irq_clr = 1'b0;
        step("R9"); step("R9");
    endtask

    initial begin
        t_reset_r1();
        t_leads_r2_r3();
        t_edge_leads_r4();
        t_override_r5_r6();
        t_monitor_r7_r8();
        t_ack_r9();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule